// File: doc/BRIEF.md
# Strided Local Memory Address Generator

This block sits inside a local memory unit and turns a small set of walk parameters into a stream of buffer addresses, one per clock cycle. A walk consists of several runs of consecutive words. Each run is a fixed number of words long. Between runs the base address jumps by a programmed step. Together these four values (first address, words per run, number of runs and step) describe one neighbour access of a stencil kernel. Addresses are ADDR_W bits wide and wrap around the buffer, whose depth is 2^ADDR_W words.

A one-cycle `go` pulse arms the unit for one tile. It captures the walk parameters and the direction bit at that moment. It then waits for the transfer engine's buffer flag: a read tile waits for `buf_not_empty` and a write tile waits for `buf_not_full`. Once that flag is seen, the walk runs without further gating. Each address comes with a valid flag, with a read or write strobe, and with a count of the runs still to go. In the cycle after the last address, `commit` pulses once so that the transfer engine can refill or drain the buffer.

Top module: `lmu_addr_walker`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `addr_valid`, `rd_en`, `wr_en`, `commit` and `busy` are 0 and `runs_left` is 0.
- R2: A `go` pulse seen while `busy` is 0 raises `busy` the next cycle. It captures the start address, length, copy count, stride and `cfg_write`. Changes to these inputs after that edge have no effect on the tile.
- R3: A read tile (`cfg_write`=0) emits nothing while `buf_not_empty` is 0, whatever the value of `buf_not_full`. A write tile (`cfg_write`=1) emits nothing while `buf_not_full` is 0, whatever the value of `buf_not_empty`.
- R4: The first address equals the start address. It is valid in the cycle after the edge at which the matching buffer flag is first sampled high.
- R5: Within a run, each valid address is the previous one plus 1, and one new address is issued every cycle.
- R6: The first address of run r (0-based) is start + r*stride.
- R7: Every address arithmetic wraps modulo 4096.
- R8: `runs_left` reads copy-1 during the first run, decreases by 1 at each new run, and reads 0 during the final run.
- R9: Exactly length*copy valid addresses are issued. In the following cycle `addr_valid` is 0 and `commit` is 1 for one cycle, and `busy` is 0 the cycle after that.
- R10: `rd_en` equals `addr_valid` for a read tile and `wr_en` equals `addr_valid` for a write tile. The other strobe stays 0.
- R11: A tile with length 0 or copy 0 issues no address. `commit` pulses in the cycle after the buffer flag is sampled high.
- R12: A `go` pulse while `busy` is 1 is ignored. No second tile follows the current one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| go | input | 1 | One-cycle tile start request |
| cfg_write | input | 1 | Tile direction: 0 read, 1 write |
| cfg_start | input | ADDR_W | First address of the walk |
| cfg_len | input | LEN_W | Words per run |
| cfg_copy | input | CNT_W | Number of runs |
| cfg_stride | input | ADDR_W | Base step between runs |
| buf_not_empty | input | 1 | Buffer holds data (gates read tiles) |
| buf_not_full | input | 1 | Buffer has room (gates write tiles) |
| busy | output | 1 | Tile armed or in progress |
| addr | output | ADDR_W | Current buffer address |
| addr_valid | output | 1 | `addr` is live this cycle |
| rd_en | output | 1 | Read strobe |
| wr_en | output | 1 | Write strobe |
| runs_left | output | CNT_W | Runs remaining after the current one |
| commit | output | 1 | Tile finished, buffer released |

## Verification
The gate properties assume that a buffer flag sampled high at the edge that starts a walk was already high in the cycle before it. The stimulus therefore changes the flags only at the falling edge and keeps them steady during each cycle. The step properties assume the walk is never cut short, so the bench never pulses reset in the middle of a tile. Configuration inputs are treated as don't-care after `go`. The bench scrambles them on purpose once each tile has been armed.

// File: rtl/lmu_agen_pkg.sv
// Shared types for the strided local memory address generator.
package lmu_agen_pkg;
    // Tile phases: idle, armed waiting for the buffer flag, walking, releasing.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2,
        ST_DONE = 2'd3
    } gate_state_t;
endpackage

// File: rtl/lmu_tile_gate.sv
// Tile handshake controller.
// Accepts a start request only when idle and waits for the buffer flag that
// matches the tile direction. It then lets the walker step until it flags
// its final address, and pulses a release for one cycle.
// Assumes: walk_last is only meaningful while walking.
module lmu_tile_gate
    import lmu_agen_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go_i,
    input  logic write_i,     // latched direction
    input  logic empty_cfg_i, // latched walk has no addresses
    input  logic not_empty_i,
    input  logic not_full_i,
    input  logic walk_last_i,
    output logic accept_o,
    output logic load_o,
    output logic step_o,
    output logic busy_o,
    output logic active_o,
    output logic release_o
);
    gate_state_t state_q, state_d;
    logic        flag_ok;

    // Pick the buffer flag that gates this tile's direction.
    always_comb flag_ok = write_i ? not_full_i : not_empty_i;

    // Next-state logic for the tile phases.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (go_i) state_d = ST_WAIT;
            ST_WAIT: if (flag_ok) state_d = empty_cfg_i ? ST_DONE : ST_RUN;
            ST_RUN:  if (walk_last_i) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Control strobes derived from the current phase.
    always_comb begin
        accept_o  = (state_q == ST_IDLE) && go_i;
        load_o    = (state_q == ST_WAIT) && flag_ok && !empty_cfg_i;
        step_o    = (state_q == ST_RUN);
        active_o  = (state_q == ST_RUN);
        release_o = (state_q == ST_DONE);
        busy_o    = (state_q != ST_IDLE);
    end
endmodule

// File: rtl/lmu_stride_walk.sv
// Nested run/stride address counter.
// On load it starts at the given address with copy-1 runs remaining. Each
// step moves one word along the run, or to base+stride at the run's end.
// Assumes: len_i >= 1 and copy_i >= 1 whenever load_i is high.
// Address arithmetic wraps at 2^ADDR_W.
module lmu_stride_walk #(
    parameter int ADDR_W = 12,
    parameter int LEN_W  = 12,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              step_i,
    input  logic [ADDR_W-1:0] start_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [CNT_W-1:0]  copy_i,
    input  logic [ADDR_W-1:0] stride_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [CNT_W-1:0]  runs_left_o,
    output logic              last_o
);
    localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [ADDR_W-1:0] addr_q, base_q;
    logic [LEN_W-1:0]  col_q;
    logic [CNT_W-1:0]  runs_q;
    logic              run_end;

    // Detect the last word of a run and of the whole walk.
    always_comb begin
        run_end = (col_q == len_i - LEN_ONE);
        last_o  = run_end && (runs_q == '0);
    end

    // Walk counters: word within run, run base, runs still to go.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            base_q <= '0;
            col_q  <= '0;
            runs_q <= '0;
        end else if (load_i) begin
            addr_q <= start_i;
            base_q <= start_i;
            col_q  <= '0;
            runs_q <= copy_i - CNT_ONE;
        end else if (step_i && !last_o) begin
            if (run_end) begin
                addr_q <= base_q + stride_i;
                base_q <= base_q + stride_i;
                col_q  <= '0;
                runs_q <= runs_q - CNT_ONE;
            end else begin
                addr_q <= addr_q + ADDR_W'(1);
                col_q  <= col_q + LEN_ONE;
            end
        end
    end

    always_comb begin
        addr_o      = addr_q;
        runs_left_o = runs_q;
    end
endmodule

// File: rtl/lmu_addr_walker.sv
// Strided local memory address generator (top).
// Captures the walk parameters at an accepted start request. It waits for the
// buffer flag of the tile direction, streams one address per cycle with
// strobes, and pulses commit after the last address.
// Assumes: buffer depth is 2^ADDR_W words.
module lmu_addr_walker #(
    parameter int ADDR_W = 12,
    parameter int LEN_W  = 12,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              cfg_write,
    input  logic [ADDR_W-1:0] cfg_start,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic [CNT_W-1:0]  cfg_copy,
    input  logic [ADDR_W-1:0] cfg_stride,
    input  logic              buf_not_empty,
    input  logic              buf_not_full,
    output logic              busy,
    output logic [ADDR_W-1:0] addr,
    output logic              addr_valid,
    output logic              rd_en,
    output logic              wr_en,
    output logic [CNT_W-1:0]  runs_left,
    output logic              commit
);
    logic [ADDR_W-1:0] start_q, stride_q;
    logic [LEN_W-1:0]  len_q;
    logic [CNT_W-1:0]  copy_q;
    logic              write_q, empty_cfg;
    logic              accept, load, step, active, walk_last;

    // Hold the walk parameters for the whole tile.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q  <= '0;
            stride_q <= '0;
            len_q    <= '0;
            copy_q   <= '0;
            write_q  <= 1'b0;
        end else if (accept) begin
            start_q  <= cfg_start;
            stride_q <= cfg_stride;
            len_q    <= cfg_len;
            copy_q   <= cfg_copy;
            write_q  <= cfg_write;
        end
    end

    // A walk with no words or no runs produces no address.
    always_comb empty_cfg = (len_q == '0) || (copy_q == '0);

    lmu_tile_gate u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .go_i        (go),
        .write_i     (write_q),
        .empty_cfg_i (empty_cfg),
        .not_empty_i (buf_not_empty),
        .not_full_i  (buf_not_full),
        .walk_last_i (walk_last),
        .accept_o    (accept),
        .load_o      (load),
        .step_o      (step),
        .busy_o      (busy),
        .active_o    (active),
        .release_o   (commit)
    );

    lmu_stride_walk #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W),
        .CNT_W  (CNT_W)
    ) u_walk (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load),
        .step_i      (step),
        .start_i     (start_q),
        .len_i       (len_q),
        .copy_i      (copy_q),
        .stride_i    (stride_q),
        .addr_o      (addr),
        .runs_left_o (runs_left),
        .last_o      (walk_last)
    );

    // Output qualifiers and direction strobes.
    always_comb begin
        addr_valid = active;
        rd_en      = active && !write_q;
        wr_en      = active && write_q;
    end
endmodule

// File: rtl/lmu_addr_walker_chk.sv
// Protocol checker for lmu_addr_walker, attached by bind.
// Assumes: reset is held from time zero and buffer flags change away from edges.
module lmu_addr_walker_chk #(
    parameter int ADDR_W = 12,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              buf_not_empty,
    input logic              buf_not_full,
    input logic              busy,
    input logic [ADDR_W-1:0] addr,
    input logic              addr_valid,
    input logic              rd_en,
    input logic              wr_en,
    input logic [CNT_W-1:0]  runs_left,
    input logic              commit
);
    // R5
    run_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid && $past(addr_valid) && runs_left == $past(runs_left)
        |-> addr == $past(addr) + ADDR_W'(1));

    // R8
    runs_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid && $past(addr_valid) && runs_left != $past(runs_left)
        |-> runs_left == $past(runs_left) - CNT_W'(1));

    // R9
    commit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !addr_valid && busy);

    // R9
    commit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit && !busy);

    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && wr_en) && ((rd_en || wr_en) == addr_valid));

    // R3
    read_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_en) |-> $past(buf_not_empty));

    // R3
    write_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_en) |-> $past(buf_not_full));
endmodule

bind lmu_addr_walker lmu_addr_walker_chk #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .buf_not_empty (buf_not_empty),
    .buf_not_full  (buf_not_full),
    .busy          (busy),
    .addr          (addr),
    .addr_valid    (addr_valid),
    .rd_en         (rd_en),
    .wr_en         (wr_en),
    .runs_left     (runs_left),
    .commit        (commit)
);

// File: tb/lmu_addr_walker_test.sv
`timescale 1ns/1ps
// Sweeps small walk shapes and checks every issued address arithmetically.
module lmu_addr_walker_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        go = 1'b0;
    logic        cfg_write = 1'b0;
    logic [11:0] cfg_start = '0;
    logic [11:0] cfg_len = '0;
    logic [7:0]  cfg_copy = '0;
    logic [11:0] cfg_stride = '0;
    logic        buf_not_empty = 1'b0;
    logic        buf_not_full = 1'b0;
    logic        busy, addr_valid, rd_en, wr_en, commit;
    logic [11:0] addr;
    logic [7:0]  runs_left;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    lmu_addr_walker uut (
        .clk(clk), .rst_n(rst_n), .go(go), .cfg_write(cfg_write),
        .cfg_start(cfg_start), .cfg_len(cfg_len), .cfg_copy(cfg_copy),
        .cfg_stride(cfg_stride), .buf_not_empty(buf_not_empty),
        .buf_not_full(buf_not_full), .busy(busy), .addr(addr),
        .addr_valid(addr_valid), .rd_en(rd_en), .wr_en(wr_en),
        .runs_left(runs_left), .commit(commit)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One tile: arm, hold the gate low for `hold` cycles, then walk and check.
    task automatic run_tile(input int start, input int len, input int copy,
                            input int stride, input bit wr, input int hold,
                            input bit extra_go);
        @(negedge clk);
        cfg_start = 12'(start); cfg_len = 12'(len); cfg_copy = 8'(copy);
        cfg_stride = 12'(stride); cfg_write = wr; go = 1'b1;
        buf_not_empty = wr;      // wrong flag high, right flag low
        buf_not_full  = !wr;
        @(negedge clk);
        go = 1'b0;
        // R2: scramble configuration after capture
        cfg_start = 12'(start + 77); cfg_len = 12'(len + 3);
        cfg_copy = 8'(copy + 2); cfg_stride = 12'(stride + 9); cfg_write = !wr;
        chk(busy == 1'b1, "R2", "busy after go", int'(busy), 1);
        for (int h = 0; h < hold; h++) begin
            chk(addr_valid == 1'b0, "R3", "no address while gated", int'(addr_valid), 0);
            @(negedge clk);
        end
        if (wr) buf_not_full = 1'b1; else buf_not_empty = 1'b1;
        @(negedge clk);
        for (int r = 0; r < copy; r++) begin
            for (int i = 0; i < len; i++) begin
                int exp_a;
                exp_a = (start + r * stride + i) % 4096;
                chk(addr_valid == 1'b1, "R9", "valid during walk", int'(addr_valid), 1);
                if (r == 0 && i == 0)
                    chk(int'(addr) == exp_a, "R4", "first address", int'(addr), exp_a);
                else if (i == 0)
                    chk(int'(addr) == exp_a, "R6", "run base", int'(addr), exp_a);
                else
                    chk(int'(addr) == exp_a, "R5", "run step", int'(addr), exp_a);
                chk(int'(runs_left) == copy - 1 - r, "R8", "runs_left",
                    int'(runs_left), copy - 1 - r);
                chk(rd_en == !wr && wr_en == wr, "R10", "strobes",
                    int'({rd_en, wr_en}), int'({!wr, wr}));
                if (extra_go && r == 0 && i == 0) go = 1'b1;  // R12 stimulus
                @(negedge clk);
                go = 1'b0;
            end
        end
        chk(addr_valid == 1'b0, "R9", "valid drop after last", int'(addr_valid), 0);
        chk(commit == 1'b1, (len == 0 || copy == 0) ? "R11" : "R9", "commit pulse",
            int'(commit), 1);
        @(negedge clk);
        chk(commit == 1'b0, "R9", "commit single", int'(commit), 0);
        chk(busy == 1'b0, extra_go ? "R12" : "R9", "idle after tile", int'(busy), 0);
        buf_not_empty = 1'b0; buf_not_full = 1'b0;
        if (extra_go) begin
            repeat (3) begin
                @(negedge clk);
                chk(busy == 1'b0 && addr_valid == 1'b0, "R12", "no second tile",
                    int'(busy), 0);
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(addr_valid == 0 && busy == 0 && commit == 0, "R1", "in reset",
            int'({addr_valid, busy, commit}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(addr_valid == 0 && rd_en == 0 && wr_en == 0 && commit == 0 && busy == 0,
            "R1", "after reset", int'({addr_valid, rd_en, wr_en, commit, busy}), 0);
        chk(runs_left == 0, "R1", "runs_left reset", int'(runs_left), 0);
        // Near-exhaustive sweep of small shapes, both directions.
        for (int len = 1; len <= 4; len++)
            for (int cp = 1; cp <= 3; cp++)
                for (int wr = 0; wr < 2; wr++)
                    run_tile(6 + len * 11, len, cp, 5 + cp, wr[0], (len + cp) % 3, 1'b0);
        run_tile(6, 3, 3, 5, 1'b0, 2, 1'b0);            // canonical neighbour walk
        run_tile(4094, 3, 3, 3, 1'b0, 1, 1'b0);         // R7 wrap within run
        run_tile(4090, 2, 4, 4000, 1'b1, 0, 1'b0);      // R7 wrap via stride
        run_tile(100, 0, 3, 5, 1'b0, 1, 1'b0);          // R11 zero length
        run_tile(100, 4, 0, 5, 1'b1, 2, 1'b0);          // R11 zero copy
        run_tile(200, 3, 2, 7, 1'b0, 1, 1'b1);          // R12 go while busy
        run_tile(300, 1, 1, 0, 1'b1, 4, 1'b1);          // single word, R12
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule